// File: doc/BRIEF.md
# Multiplexed Bus Machine-Cycle Sequencer

This block produces the pin-level timing of a single bus machine cycle for a small 8-bit processor. The processor's low address byte and its data byte share one set of AD lines. A one-cycle start pulse, a cycle kind, a 16-bit address and, for stores, a data byte launch the cycle. The sequencer then walks through its T-states. It places the address, pulses the address latch enable, and drives the active-low read or write strobe. It also presents the three status lines that tell external logic what kind of cycle is under way.

Some events land mid-state: the latch enable drops and the strobes release half a clock into a T-state. A small bank of falling-edge registers produces these. For loads, the block samples the AD lines at the middle of the last bus T-state and returns that byte with a one-cycle completion pulse. The surrounding core issues one request per cycle and waits for that pulse before it uses the data.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is asserted and while no cycle runs, rd_n_o and wr_n_o are 1, ale_o is 0, ad_oe_o is 0, addr_hi_o is 0, io_m_o/s1_o/s0_o are 0, and done_o is 0.
- R2: A cycle starts in the clock after the edge that samples start_i. An opcode fetch (kind 0) lasts four T-states and every other kind lasts three. done_o is 1 for exactly one clock, the one right after the last T-state.
- R3: In T1, ad_oe_o is 1 and ad_o carries addr_i[7:0]. For memory kinds, addr_hi_o carries addr_i[15:8]. For I/O kinds (3 and 4), the port number addr_i[7:0] appears on both addr_hi_o and ad_o. addr_hi_o keeps that value through T3.
- R4: ale_o rises at the start of T1 and falls at the falling clock edge in the middle of T1.
- R5: For fetch, memory read and I/O read (kinds 0, 1, 3), rd_n_o is 0 from the start of T2 until the falling edge in the middle of T3. ad_oe_o is 0 from T2 onward, so the AD lines are never driven while rd_n_o is 0.
- R6: On a read kind, the byte on ad_i at the falling edge in the middle of T3 is captured. It appears on rdata_o while done_o is 1 and holds until the next read. Write kinds leave rdata_o unchanged.
- R7: For memory write and I/O write (kinds 2 and 4), wr_n_o is 0 from the start of T2 until the middle of T3. ad_o carries wdata_i with ad_oe_o at 1 from the start of T2 to the end of T3. rd_n_o and wr_n_o are never both 0.
- R8: {io_m_o,s1_o,s0_o} are set by the kind: fetch 011, memory read 010, memory write 001, I/O read 110, I/O write 101. They hold steady from T1 through the last T-state.
- R9: In T4 of a fetch, rd_n_o and wr_n_o are 1, ale_o and ad_oe_o are 0, and addr_hi_o is 0. The status lines keep the fetch code.
- R10: start_i is ignored while a cycle runs, and is also ignored with kind codes 5 to 7. Neither case changes the strobes, the address, the length of the running cycle, or rdata_o.
- R11: A start sampled in the clock where done_o is 1 is accepted. Its T1 follows at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one T-state |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, sampled on the rising edge while idle |
| kind_i | input | 3 | Cycle kind: 0 fetch, 1 mem read, 2 mem write, 3 I/O read, 4 I/O write |
| addr_i | input | 16 | Cycle address (port number in bits 7:0 for I/O) |
| wdata_i | input | 8 | Store byte for write kinds |
| ad_i | input | 8 | Sensed value of the shared AD lines |
| addr_hi_o | output | 8 | Dedicated high address lines |
| ad_o | output | 8 | Value driven on the shared AD lines |
| ad_oe_o | output | 1 | AD line output enable |
| ale_o | output | 1 | Address latch enable |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| io_m_o | output | 1 | 1 for I/O cycles, 0 for memory cycles |
| s1_o | output | 1 | Status bit 1 |
| s0_o | output | 1 | Status bit 0 |
| rdata_o | output | 8 | Captured read byte |
| done_o | output | 1 | One-clock completion pulse |

## Verification
Every kind is run with addresses whose high and low bytes differ. This separates the I/O port duplication from the plain memory address split, and a wrapped-edge fetch at the top of the address space checks the high byte alone. Each half of every T-state is sampled, which separates rising-edge from falling-edge events: the ALE drop, the strobe release and the point where read data is captured. The AD input is changed right after the mid-T3 edge, which shows the capture happens at that edge and not later. Stray starts during a running cycle, invalid kind codes, and a start in the completion clock separate an ignored request from a back-to-back acceptance.

// File: rtl/busseq_pkg.sv
package busseq_pkg;

  typedef enum logic [2:0] {
    K_FETCH = 3'd0,
    K_MRD   = 3'd1,
    K_MWR   = 3'd2,
    K_IORD  = 3'd3,
    K_IOWR  = 3'd4
  } kind_e;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_T4   = 3'd4
  } tstate_e;

  function automatic logic kind_valid(input logic [2:0] k);
    return (k <= K_IOWR);
  endfunction

  function automatic logic kind_reads(input logic [2:0] k);
    return (k == K_FETCH) || (k == K_MRD) || (k == K_IORD);
  endfunction

  function automatic logic kind_writes(input logic [2:0] k);
    return (k == K_MWR) || (k == K_IOWR);
  endfunction

  function automatic logic kind_is_io(input logic [2:0] k);
    return (k == K_IORD) || (k == K_IOWR);
  endfunction

  function automatic logic kind_long(input logic [2:0] k);
    return (k == K_FETCH);
  endfunction

  // {io_m, s1, s0}
  function automatic logic [2:0] kind_status(input logic [2:0] k);
    logic [2:0] s;
    case (k)
      K_FETCH: s = 3'b011;
      K_MRD:   s = 3'b010;
      K_MWR:   s = 3'b001;
      K_IORD:  s = 3'b110;
      K_IOWR:  s = 3'b101;
      default: s = 3'b000;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/busseq_tstate.sv
module busseq_tstate
  import busseq_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output tstate_e           state_o,
  output logic [2:0]        kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              done_o
);

  tstate_e           state_q, state_d;
  logic              done_q, done_d;
  logic              load_en;
  logic [2:0]        kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    load_en = 1'b0;
    case (state_q)
      TS_IDLE: begin
        if (start_i && kind_valid(kind_i)) begin
          state_d = TS_T1;
          load_en = 1'b1;
        end
      end
      TS_T1: state_d = TS_T2;
      TS_T2: state_d = TS_T3;
      TS_T3: begin
        if (kind_long(kind_q)) begin
          state_d = TS_T4;
        end else begin
          state_d = TS_IDLE;
          done_d  = 1'b1;
        end
      end
      TS_T4: begin
        state_d = TS_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TS_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= 3'd0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load_en) begin
      kind_q  <= kind_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  assign state_o = state_q;
  assign kind_o  = kind_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign done_o  = done_q;

  // R10: a running cycle is never restarted or shortened
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TS_T1) |=> (state_q == TS_T2));

  // R2: completion is a single-clock pulse
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R2: completion only follows a final T-state
  assert_done_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(state_q) == TS_T3 || $past(state_q) == TS_T4));

  // R9: only a fetch reaches T4
  assert_t4_only_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TS_T4) |-> (kind_q == K_FETCH));

endmodule

// File: rtl/busseq_midedge.sv
module busseq_midedge
  import busseq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tstate_e           state_i,
  input  logic [2:0]        kind_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic              t1_late_o,
  output logic              t3_late_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic              t1_late_q, t3_late_q;
  logic [DATA_W-1:0] rdata_q;
  logic              cap_en;

  assign cap_en = (state_i == TS_T3) && kind_reads(kind_i);

  // Falling-edge flags mark the second half of T1 and T3
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t1_late_q <= 1'b0;
      t3_late_q <= 1'b0;
    end else begin
      t1_late_q <= (state_i == TS_T1);
      t3_late_q <= (state_i == TS_T3);
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (cap_en) begin
      rdata_q <= ad_i;
    end
  end

  assign t1_late_o = t1_late_q;
  assign t3_late_o = t3_late_q;
  assign rdata_o   = rdata_q;

  // R6: captured data only moves after a read T3
  assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !((state_i == TS_T3) || ($past(state_i) == TS_T3)) |-> $stable(rdata_q));

endmodule

// File: rtl/busseq_pins.sv
module busseq_pins
  import busseq_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tstate_e           state_i,
  input  logic [2:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              t1_late_i,
  input  logic              t3_late_i,
  output logic [DATA_W-1:0] addr_hi_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic              ale_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic [2:0]        status_o
);

  logic in_t1, in_t2, in_t3, in_bus, in_cycle, strobe_win, wr_phase;
  logic [DATA_W-1:0] lo_byte, hi_byte;

  assign in_t1    = (state_i == TS_T1);
  assign in_t2    = (state_i == TS_T2);
  assign in_t3    = (state_i == TS_T3);
  assign in_bus   = in_t1 | in_t2 | in_t3;
  assign in_cycle = (state_i != TS_IDLE);

  assign lo_byte = addr_i[DATA_W-1:0];
  assign hi_byte = kind_is_io(kind_i) ? addr_i[DATA_W-1:0] : addr_i[ADDR_W-1:DATA_W];

  assign strobe_win = in_t2 | (in_t3 & ~t3_late_i);
  assign wr_phase   = kind_writes(kind_i) & (in_t2 | in_t3);

  always_comb begin
    ale_o     = in_t1 & ~t1_late_i;
    rd_n_o    = ~(strobe_win & kind_reads(kind_i));
    wr_n_o    = ~(strobe_win & kind_writes(kind_i));
    addr_hi_o = in_bus ? hi_byte : '0;
    ad_oe_o   = in_t1 | wr_phase;
    if (in_t1) begin
      ad_o = lo_byte;
    end else if (wr_phase) begin
      ad_o = wdata_i;
    end else begin
      ad_o = '0;
    end
    status_o = in_cycle ? kind_status(kind_i) : 3'b000;
  end

  // R7: the two strobes never overlap
  assert_strobe_exclusive_R7: assert property (@(negedge clk) disable iff (!rst_n)
    !(!rd_n_o && !wr_n_o));

  // R5: no drive on the AD lines while a read strobe is active
  assert_no_contention_R5: assert property (@(negedge clk) disable iff (!rst_n)
    !rd_n_o |-> !ad_oe_o);

  // R4: latch enable only during an address phase with no strobe
  assert_ale_addr_phase_R4: assert property (@(negedge clk) disable iff (!rst_n)
    ale_o |-> (ad_oe_o && rd_n_o && wr_n_o));

  // R8: status steady across the cycle
  assert_status_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_t2 || in_t3 || state_i == TS_T4) |-> $stable(status_o));

  // R9: bus quiet in the decode state
  assert_t4_quiet_R9: assert property (@(negedge clk) disable iff (!rst_n)
    (state_i == TS_T4) |-> (rd_n_o && wr_n_o && !ad_oe_o && !ale_o));

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import busseq_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] addr_hi_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic              ale_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              io_m_o,
  output logic              s1_o,
  output logic              s0_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  tstate_e           state;
  logic [2:0]        kind_l;
  logic [ADDR_W-1:0] addr_l;
  logic [DATA_W-1:0] wdata_l;
  logic              t1_late, t3_late;
  logic [2:0]        status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  busseq_tstate #(.DATA_W(DATA_W)) u_tstate (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (start_i),
    .kind_i  (kind_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .state_o (state),
    .kind_o  (kind_l),
    .addr_o  (addr_l),
    .wdata_o (wdata_l),
    .done_o  (done_o)
  );

  busseq_midedge #(.DATA_W(DATA_W)) u_midedge (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .state_i   (state),
    .kind_i    (kind_l),
    .ad_i      (ad_i),
    .t1_late_o (t1_late),
    .t3_late_o (t3_late),
    .rdata_o   (rdata_o)
  );

  busseq_pins #(.DATA_W(DATA_W)) u_pins (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .state_i   (state),
    .kind_i    (kind_l),
    .addr_i    (addr_l),
    .wdata_i   (wdata_l),
    .t1_late_i (t1_late),
    .t3_late_i (t3_late),
    .addr_hi_o (addr_hi_o),
    .ad_o      (ad_o),
    .ad_oe_o   (ad_oe_o),
    .ale_o     (ale_o),
    .rd_n_o    (rd_n_o),
    .wr_n_o    (wr_n_o),
    .status_o  (status)
  );

  assign io_m_o = status[2];
  assign s1_o   = status[1];
  assign s0_o   = status[0];

endmodule

// File: tb/bus_cycle_seq_bench.sv
`timescale 1ns/100ps
module bus_cycle_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [2:0]  kind_i;
  logic [15:0] addr_i;
  logic [7:0]  wdata_i, ad_i;
  logic [7:0]  addr_hi_o, ad_o, rdata_o;
  logic        ad_oe_o, ale_o, rd_n_o, wr_n_o, io_m_o, s1_o, s0_o, done_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [7:0] last_rd = 8'h00;

  always #2 clk = ~clk;

  bus_cycle_seq u_bus_cycle_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .ad_i(ad_i),
    .addr_hi_o(addr_hi_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .ale_o(ale_o),
    .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .io_m_o(io_m_o), .s1_o(s1_o),
    .s0_o(s0_o), .rdata_o(rdata_o), .done_o(done_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk({req, " rd_n"}, rd_n_o, 1);
    chk({req, " wr_n"}, wr_n_o, 1);
    chk({req, " ale"}, ale_o, 0);
    chk({req, " oe"}, ad_oe_o, 0);
    chk({req, " hi"}, addr_hi_o, 0);
    chk({req, " status"}, {io_m_o, s1_o, s0_o}, 0);
  endtask

  function automatic logic [2:0] exp_status(input logic [2:0] k);
    case (k)
      3'd0: return 3'b011;
      3'd1: return 3'b010;
      3'd2: return 3'b001;
      3'd3: return 3'b110;
      default: return 3'b101;
    endcase
  endfunction

  task automatic step_pos(); @(posedge clk); #1; endtask
  task automatic step_neg(); @(negedge clk); #1; endtask

  // One full cycle of the given kind, checking both halves of every T-state
  task automatic run_cycle(input logic [2:0] k, input logic [15:0] a,
                           input logic [7:0] w, input logic [7:0] mem);
    logic io, rd, wr;
    logic [7:0] hi;
    io = (k == 3) || (k == 4);
    rd = (k == 0) || (k == 1) || (k == 3);
    wr = (k == 2) || (k == 4);
    hi = io ? a[7:0] : a[15:8];
    step_pos();
    start_i = 1; kind_i = k; addr_i = a; wdata_i = w; ad_i = mem;
    step_pos();                                   // T1, first half
    start_i = 0;
    chk("R4 ale high early T1", ale_o, 1);
    chk("R3 oe in T1", ad_oe_o, 1);
    chk("R3 ad low byte", ad_o, a[7:0]);
    chk("R3 high lines", addr_hi_o, hi);
    chk("R8 status", {io_m_o, s1_o, s0_o}, exp_status(k));
    chk("R5 rd_n idle in T1", rd_n_o, 1);
    chk("R7 wr_n idle in T1", wr_n_o, 1);
    chk("R2 done low in T1", done_o, 0);
    step_neg();                                   // T1, second half
    chk("R4 ale low mid T1", ale_o, 0);
    chk("R3 ad held late T1", ad_o, a[7:0]);
    step_pos();                                   // T2
    chk("R5 rd_n T2", rd_n_o, !rd);
    chk("R7 wr_n T2", wr_n_o, !wr);
    chk("R5 R7 oe T2", ad_oe_o, wr);
    if (wr) chk("R7 wdata T2", ad_o, w);
    chk("R3 high lines T2", addr_hi_o, hi);
    chk("R8 status T2", {io_m_o, s1_o, s0_o}, exp_status(k));
    step_neg();
    chk("R5 rd_n late T2", rd_n_o, !rd);
    chk("R7 wr_n late T2", wr_n_o, !wr);
    step_pos();                                   // T3
    chk("R5 rd_n early T3", rd_n_o, !rd);
    chk("R7 wr_n early T3", wr_n_o, !wr);
    chk("R3 high lines T3", addr_hi_o, hi);
    if (wr) chk("R7 wdata T3", ad_o, w);
    step_neg();                                   // T3, second half
    chk("R5 rd_n released mid T3", rd_n_o, 1);
    chk("R7 wr_n released mid T3", wr_n_o, 1);
    chk("R7 oe to end T3", ad_oe_o, wr);
    ad_i = ~mem;
    if (k == 0) begin
      step_pos();                                 // T4
      chk("R2 done low in T4", done_o, 0);
      chk("R9 rd_n T4", rd_n_o, 1);
      chk("R9 oe T4", ad_oe_o, 0);
      chk("R9 hi T4", addr_hi_o, 0);
      chk("R9 status T4", {io_m_o, s1_o, s0_o}, 3'b011);
    end
    step_pos();                                   // completion clock
    chk("R2 done pulse", done_o, 1);
    if (rd) last_rd = mem;
    chk("R6 rdata", rdata_o, last_rd);
    chk_idle("R1 after cycle");
    step_pos();
    chk("R2 done one clock", done_o, 0);
  endtask

  task automatic test_reset();
    rst_n = 0; start_i = 0; kind_i = 0; addr_i = 0; wdata_i = 0; ad_i = 0;
    step_pos(); step_pos();
    chk_idle("R1 in reset");
    chk("R1 done in reset", done_o, 0);
    rst_n = 1;
    step_pos(); step_pos(); step_pos();
    chk_idle("R1 after reset");
    chk("R1 done after reset", done_o, 0);
  endtask

  task automatic test_ignore();
    step_pos();
    start_i = 1; kind_i = 1; addr_i = 16'h1234; ad_i = 8'h5A;
    step_pos();                                   // T1
    start_i = 0;
    step_pos();                                   // T2: stray request
    start_i = 1; kind_i = 2; addr_i = 16'hFFFF; wdata_i = 8'h99;
    step_pos();                                   // T3
    chk("R10 rd_n kept", rd_n_o, 0);
    chk("R10 wr_n not started", wr_n_o, 1);
    chk("R10 high lines kept", addr_hi_o, 8'h12);
    start_i = 0;
    step_pos();
    chk("R10 length kept", done_o, 1);
    chk("R10 rdata", rdata_o, 8'h5A);
    last_rd = 8'h5A;
    step_pos();
    chk("R10 no extra cycle", ale_o, 0);
    chk("R10 no extra done", done_o, 0);
    start_i = 1; kind_i = 6; addr_i = 16'hABCD;   // invalid kind
    step_pos();
    start_i = 0;
    chk_idle("R10 bad kind");
    step_pos(); step_pos(); step_pos();
    chk("R10 bad kind no done", done_o, 0);
    chk("R10 bad kind rdata", rdata_o, 8'h5A);
  endtask

  task automatic test_back_to_back();
    step_pos();
    start_i = 1; kind_i = 3; addr_i = 16'h7740; ad_i = 8'hA5;
    step_pos(); start_i = 0;
    step_pos(); step_pos();
    step_pos();                                   // completion clock
    chk("R11 first done", done_o, 1);
    chk("R11 first rdata", rdata_o, 8'hA5);
    last_rd = 8'hA5;
    start_i = 1; kind_i = 4; addr_i = 16'h00C3; wdata_i = 8'h77;
    step_pos();                                   // T1 of second
    start_i = 0;
    chk("R11 ale", ale_o, 1);
    chk("R11 hi port", addr_hi_o, 8'hC3);
    chk("R11 ad port", ad_o, 8'hC3);
    chk("R11 status", {io_m_o, s1_o, s0_o}, 3'b101);
    step_pos();
    chk("R11 wr_n", wr_n_o, 0);
    chk("R11 wdata", ad_o, 8'h77);
    step_pos(); step_pos();
    chk("R11 second done", done_o, 1);
    chk("R6 write keeps rdata", rdata_o, 8'hA5);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    test_reset();
    run_cycle(3'd0, 16'h2000, 8'h00, 8'h06);
    run_cycle(3'd1, 16'h2001, 8'h00, 8'h43);
    run_cycle(3'd2, 16'h526A, 8'h3C, 8'h11);
    run_cycle(3'd3, 16'h41C0, 8'h00, 8'h5E);
    run_cycle(3'd4, 16'h1281, 8'hE7, 8'h22);
    run_cycle(3'd0, 16'hFFFF, 8'h00, 8'h00);
    test_ignore();
    test_back_to_back();
    step_pos();
    summary();
  end

  initial begin
    #(200000 * 4);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
  end

endmodule